// File: doc/BRIEF.md
# Pedestal and Threshold Subtraction Reader

This block drives the read-out of up to 24 front-end connectors during one read window and corrects every sample on the fly. Each connector carries two cards of 32 channels. A single pulse on `win_start_i` starts a scan. The block then raises a pedestal read request and waits until the pedestal memory reports ready. It then steps through the 64 slots of the scan. The first card's channels come first, then the second card's. For each slot it drives the channel address, the card enable and the matching pedestal memory address.

For every slot the environment returns 24 raw 9-bit samples and one 192-bit pedestal word holding one 8-bit value per lane. The block registers both. In the next cycle it subtracts the pedestal from the raw value, clamps the result into 8 bits and zeroes any value below a programmable threshold. It then writes all 24 results into the connector FIFOs with one shared strobe. A one-cycle done pulse follows the last write of the window.

Top module: `ped_sub_reader`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `ped_rd_o`, `fifo_wr_o`, `read_done_o` and `card_oe_o` are 0 and `fe_addr_o`, `ped_addr_o` and `fifo_data_o` are 0.
- R2: The cycle after `win_start_i` is seen high in idle, `ped_rd_o` goes high. It stays high until the edge that accepts the last slot, then returns low. While idle it is low.
- R3: A scan is 64 slots. `fe_addr_o` carries the channel number 0..31 and `card_oe_o` is 2'b01 for slots 0..31 and 2'b10 for slots 32..63. Outside a scan `card_oe_o` is 2'b00. The first slot is shown in the cycle after `ped_ready_i` is first seen high with the request raised.
- R4: `ped_addr_o` (7 bits) equals {card index, `fe_addr_o`}. The card index is 0 for `card_oe_o`=01 and 1 for 10, so slot s maps to address (s/32)*64 + s%32.
- R5: Lane l takes its raw sample from `raw_i[9l+8:9l]` and its pedestal from `ped_i[8l+7:8l]`, and writes `fifo_data_o[8l+7:8l]`. The value is raw minus pedestal, forced to 0 when negative and to 255 when above 255.
- R6: A corrected value smaller than `thr_i` is written as 0. With `thr_i`=0 every corrected value passes unchanged.
- R7: A slot is accepted on an edge where a scan is active and `ped_ready_i` is high. `raw_i` and `ped_i` are captured on that edge. `fifo_wr_o` is high for exactly one cycle, with that slot's data, after the next edge.
- R8: `read_done_o` is high for exactly one cycle, the cycle after the 64th write of the window, and there are exactly 64 writes per window.
- R9: `win_start_i` pulses while a request or scan is in progress are ignored. The window still produces exactly 64 writes in slot order and one done pulse.
- R10: During a scan, a cycle with `ped_ready_i` low accepts no slot. Address, card enable and pedestal address hold, and no write results from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start_i | input | 1 | Read-window start pulse |
| thr_i | input | 8 | Threshold below which corrected values are zeroed |
| ped_ready_i | input | 1 | Pedestal memory ready flag |
| raw_i | input | 216 | Raw samples, 24 lanes of 9 bits |
| ped_i | input | 192 | Pedestal word, 24 lanes of 8 bits |
| fe_addr_o | output | 6 | Front-end channel address |
| card_oe_o | output | 2 | One-hot card output enable |
| ped_rd_o | output | 1 | Pedestal read request |
| ped_addr_o | output | 7 | Pedestal memory address |
| fifo_wr_o | output | 1 | Common write strobe for the 24 connector FIFOs |
| fifo_data_o | output | 192 | Corrected data, 24 lanes of 8 bits |
| read_done_o | output | 1 | End-of-window pulse |

## Verification
The sweeps place samples on both sides of the pedestal and far above it. A subtraction that wraps instead of clamping shows up as large bogus values on negative lanes, and one that truncates to 8 bits shows up as small values where 255 is expected. Thresholds of 0, 1, mid-range and 255 catch an off-by-one comparison, which would keep or drop values exactly equal to the threshold. A mid-scan drop of the ready flag catches an address counter that runs ahead, which would produce skipped slots or extra writes. A start pulse inside a scan catches a controller that restarts, which would produce more than 64 writes or a second done pulse.

// File: rtl/ped_sub_pkg.sv
package ped_sub_pkg;

  localparam int RAW_W = 9;
  localparam int PED_W = 8;
  localparam int OUT_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_SCAN = 2'd2
  } scan_state_t;

  // raw minus pedestal, floored at zero, saturated to OUT_W bits,
  // then zeroed when below the threshold
  function automatic logic [OUT_W-1:0] correct_sample(
    input logic [RAW_W-1:0] raw,
    input logic [PED_W-1:0] ped,
    input logic [OUT_W-1:0] thr
  );
    logic [RAW_W:0]     diff;
    logic [OUT_W-1:0]   clamped;
    diff = {1'b0, raw} - {{(RAW_W + 1 - PED_W){1'b0}}, ped};
    if (diff[RAW_W]) begin
      clamped = '0;
    end else if (|diff[RAW_W-1:OUT_W]) begin
      clamped = '1;
    end else begin
      clamped = diff[OUT_W-1:0];
    end
    if (clamped < thr) begin
      clamped = '0;
    end
    return clamped;
  endfunction

endpackage

// File: rtl/ped_scan_ctrl.sv
module ped_scan_ctrl
  import ped_sub_pkg::*;
#(
  parameter int CH_PER_CARD = 32,
  parameter int CARDS       = 2,
  parameter int ADDR_W      = 6,
  localparam int SLOTS      = CH_PER_CARD * CARDS,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int CH_W       = $clog2(CH_PER_CARD),
  localparam int CARD_W     = (CARDS > 1) ? $clog2(CARDS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     ready_i,
  output logic [ADDR_W-1:0]        fe_addr_o,
  output logic [CARDS-1:0]         card_oe_o,
  output logic [CARD_W+ADDR_W-1:0] ped_addr_o,
  output logic                     ped_rd_o,
  output logic                     sample_en_o,
  output logic                     sample_last_o
);

  scan_state_t       state_q;
  logic [SLOT_W-1:0] slot_q;
  logic              scanning;
  logic              at_last;
  logic [CH_W-1:0]   chan;
  logic [CARD_W-1:0] card_idx;

  assign scanning = (state_q == ST_SCAN);
  assign at_last  = (slot_q == SLOT_W'(SLOTS - 1));
  assign chan     = slot_q[CH_W-1:0];

  generate
    if (CARDS > 1) begin : g_multi_card
      assign card_idx = slot_q[SLOT_W-1:CH_W];
    end else begin : g_single_card
      assign card_idx = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          slot_q <= '0;
          if (start_i) state_q <= ST_REQ;
        end
        ST_REQ: begin
          if (ready_i) state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (ready_i) begin
            if (at_last) begin
              state_q <= ST_IDLE;
              slot_q  <= '0;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fe_addr_o  = scanning ? {{(ADDR_W - CH_W){1'b0}}, chan} : '0;
  assign ped_addr_o = scanning ? {card_idx, fe_addr_o} : '0;

  generate
    for (genvar c = 0; c < CARDS; c++) begin : g_card_oe
      assign card_oe_o[c] = scanning && (card_idx == CARD_W'(c));
    end
  endgenerate

  assign ped_rd_o      = (state_q != ST_IDLE);
  assign sample_en_o   = scanning && ready_i;
  assign sample_last_o = sample_en_o && at_last;

endmodule

// File: rtl/ped_lane.sv
module ped_lane
  import ped_sub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [RAW_W-1:0] raw_i,
  input  logic [PED_W-1:0] ped_i,
  input  logic             push_i,
  input  logic [OUT_W-1:0] thr_i,
  output logic [OUT_W-1:0] data_o
);

  logic [RAW_W-1:0] raw_q;
  logic [PED_W-1:0] ped_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      ped_q <= '0;
    end else if (cap_i) begin
      raw_q <= raw_i;
      ped_q <= ped_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o <= '0;
    end else if (push_i) begin
      data_o <= correct_sample(raw_q, ped_q, thr_i);
    end
  end

endmodule

// File: rtl/ped_sub_reader.sv
module ped_sub_reader
  import ped_sub_pkg::*;
#(
  parameter int LANES       = 24,
  parameter int CH_PER_CARD = 32,
  parameter int CARDS       = 2,
  parameter int ADDR_W      = 6,
  localparam int CARD_W     = (CARDS > 1) ? $clog2(CARDS) : 1,
  localparam int PADDR_W    = CARD_W + ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   win_start_i,
  input  logic [OUT_W-1:0]       thr_i,
  input  logic                   ped_ready_i,
  input  logic [LANES*RAW_W-1:0] raw_i,
  input  logic [LANES*PED_W-1:0] ped_i,
  output logic [ADDR_W-1:0]      fe_addr_o,
  output logic [CARDS-1:0]       card_oe_o,
  output logic                   ped_rd_o,
  output logic [PADDR_W-1:0]     ped_addr_o,
  output logic                   fifo_wr_o,
  output logic [LANES*OUT_W-1:0] fifo_data_o,
  output logic                   read_done_o
);

  // named internal events, visible to the checker
  logic sample_en;
  logic sample_last;
  logic s1_valid;
  logic s1_last;
  logic wr_last;

  ped_scan_ctrl #(
    .CH_PER_CARD(CH_PER_CARD),
    .CARDS      (CARDS),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (win_start_i),
    .ready_i      (ped_ready_i),
    .fe_addr_o    (fe_addr_o),
    .card_oe_o    (card_oe_o),
    .ped_addr_o   (ped_addr_o),
    .ped_rd_o     (ped_rd_o),
    .sample_en_o  (sample_en),
    .sample_last_o(sample_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_last     <= 1'b0;
      fifo_wr_o   <= 1'b0;
      wr_last     <= 1'b0;
      read_done_o <= 1'b0;
    end else begin
      s1_valid    <= sample_en;
      s1_last     <= sample_last;
      fifo_wr_o   <= s1_valid;
      wr_last     <= s1_valid && s1_last;
      read_done_o <= fifo_wr_o && wr_last;
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      ped_lane u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (sample_en),
        .raw_i (raw_i[l*RAW_W +: RAW_W]),
        .ped_i (ped_i[l*PED_W +: PED_W]),
        .push_i(s1_valid),
        .thr_i (thr_i),
        .data_o(fifo_data_o[l*OUT_W +: OUT_W])
      );
    end
  endgenerate

endmodule

// File: rtl/ped_sub_reader_chk.sv
module ped_sub_reader_chk #(
  parameter int LANES  = 24,
  parameter int OUT_W  = 8,
  parameter int ADDR_W = 6,
  parameter int CARDS  = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ped_ready_i,
  input logic [OUT_W-1:0]       thr_i,
  input logic [ADDR_W-1:0]      fe_addr_o,
  input logic [CARDS-1:0]       card_oe_o,
  input logic                   ped_rd_o,
  input logic                   fifo_wr_o,
  input logic [LANES*OUT_W-1:0] fifo_data_o,
  input logic                   read_done_o,
  input logic                   sample_en,
  input logic                   wr_last
);

  assert_card_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(card_oe_o));

  assert_req_in_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|card_oe_o) |-> ped_rd_o);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|card_oe_o) && !ped_ready_i) |=> ($stable(fe_addr_o) && $stable(card_oe_o)));

  assert_write_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> ##1 fifo_wr_o);

  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_o && wr_last) |=> read_done_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    read_done_o |=> !read_done_o);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_thr
      assert_thr_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> ((fifo_data_o[l*OUT_W +: OUT_W] == '0) ||
                       (fifo_data_o[l*OUT_W +: OUT_W] >= thr_i)));
    end
  endgenerate

endmodule

bind ped_sub_reader ped_sub_reader_chk #(
  .LANES (LANES),
  .OUT_W (ped_sub_pkg::OUT_W),
  .ADDR_W(ADDR_W),
  .CARDS (CARDS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ped_ready_i(ped_ready_i),
  .thr_i      (thr_i),
  .fe_addr_o  (fe_addr_o),
  .card_oe_o  (card_oe_o),
  .ped_rd_o   (ped_rd_o),
  .fifo_wr_o  (fifo_wr_o),
  .fifo_data_o(fifo_data_o),
  .read_done_o(read_done_o),
  .sample_en  (sample_en),
  .wr_last    (wr_last)
);

// File: tb/test_ped_sub_reader.sv
module test_ped_sub_reader;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         win_start_i = 1'b0;
  logic [7:0]   thr_i = 8'd0;
  logic         ped_ready_i = 1'b0;
  logic [215:0] raw_i;
  logic [191:0] ped_i;
  logic [5:0]   fe_addr_o;
  logic [1:0]   card_oe_o;
  logic         ped_rd_o;
  logic [6:0]   ped_addr_o;
  logic         fifo_wr_o;
  logic [191:0] fifo_data_o;
  logic         read_done_o;

  int n_chk = 0;
  int n_fail = 0;
  int cur_seed = 0;
  int acnt = 0;
  int wcnt = 0;
  int done_cnt = 0;
  bit acc_p1 = 0;
  bit acc_p2 = 0;
  bit wr_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ped_sub_reader i_ped_sub_reader (
    .clk(clk), .rst_n(rst_n), .win_start_i(win_start_i), .thr_i(thr_i),
    .ped_ready_i(ped_ready_i), .raw_i(raw_i), .ped_i(ped_i),
    .fe_addr_o(fe_addr_o), .card_oe_o(card_oe_o), .ped_rd_o(ped_rd_o),
    .ped_addr_o(ped_addr_o), .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o),
    .read_done_o(read_done_o)
  );

  function automatic int raw_val(int l, int k, int seed);
    return (l * 37 + k * 13 + seed * 29) % 512;
  endfunction

  function automatic int ped_val(int l, int k, int seed);
    return (l * 19 + k * 5 + seed * 7 + 64) % 256;
  endfunction

  function automatic int expect_lane(int l, int k, int seed, int thr);
    int d;
    d = raw_val(l, k, seed) - ped_val(l, k, seed);
    if (d < 0) d = 0;
    if (d > 255) d = 255;
    if (d < thr) d = 0;
    return d;
  endfunction

  // environment: answer the presented slot
  always_comb begin
    int k;
    k = (card_oe_o[1] ? 32 : 0) + int'(fe_addr_o[4:0]);
    for (int l = 0; l < NL; l++) begin
      raw_i[l*9 +: 9] = 9'(raw_val(l, k, cur_seed));
      ped_i[l*8 +: 8] = 8'(ped_val(l, k, cur_seed));
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // monitor at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit scanning;
      scanning = (card_oe_o != 2'b00);
      if (scanning) begin
        chk(fe_addr_o == 6'(acnt % 32), "R3", "channel address", fe_addr_o, acnt % 32);
        chk(card_oe_o == (acnt < 32 ? 2'b01 : 2'b10), "R3", "card enable",
            card_oe_o, acnt < 32 ? 1 : 2);
        chk(ped_addr_o == 7'((acnt / 32) * 64 + acnt % 32), "R4", "pedestal address",
            ped_addr_o, (acnt / 32) * 64 + acnt % 32);
        chk(ped_rd_o == 1'b1, "R2", "request during scan", ped_rd_o, 1);
      end
      chk(fifo_wr_o == acc_p2, "R7_R10", "write strobe timing", fifo_wr_o, acc_p2);
      if (fifo_wr_o) begin
        int bad;
        bad = -1;
        for (int l = 0; l < NL; l++) begin
          if (bad < 0 && int'(fifo_data_o[l*8 +: 8]) != expect_lane(l, wcnt, cur_seed, int'(thr_i)))
            bad = l;
        end
        if (bad < 0) chk(1'b1, "R5_R6", "lane data", 0, 0);
        else chk(1'b0, "R5_R6", $sformatf("lane %0d slot %0d data", bad, wcnt),
                 fifo_data_o[bad*8 +: 8], expect_lane(bad, wcnt, cur_seed, int'(thr_i)));
        wcnt++;
      end
      if (read_done_o) begin
        chk(wcnt == 64, "R8", "writes before done", wcnt, 64);
        chk(wr_prev, "R8", "write in cycle before done", int'(wr_prev), 1);
        done_cnt++;
      end
      wr_prev = fifo_wr_o;
      acc_p2 = acc_p1;
      acc_p1 = scanning && ped_ready_i;
      if (scanning && ped_ready_i) acnt++;
    end
  end

  task automatic run_window(int seed, int thr, bit stall, bit dup);
    cur_seed = seed;
    thr_i = 8'(thr);
    acnt = 0;
    wcnt = 0;
    done_cnt = 0;
    ped_ready_i = 1'b0;
    win_start_i = 1'b1;
    tick();
    win_start_i = 1'b0;
    chk(ped_rd_o == 1'b1, "R2", "request after start", ped_rd_o, 1);
    chk(card_oe_o == 2'b00, "R3", "no scan before ready", card_oe_o, 0);
    tick();
    tick();
    chk(card_oe_o == 2'b00, "R3", "still waiting for ready", card_oe_o, 0);
    chk(fifo_wr_o == 1'b0, "R3", "no write while waiting", fifo_wr_o, 0);
    ped_ready_i = 1'b1;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (stall && i == 20) ped_ready_i = 1'b0;
      if (stall && i == 26) ped_ready_i = 1'b1;
      win_start_i = (dup && (i == 30 || i == 2)) ? 1'b1 : 1'b0;
      if (done_cnt > 0) break;
    end
    win_start_i = 1'b0;
    repeat (4) tick();
    chk(wcnt == 64, "R8_R9", "writes per window", wcnt, 64);
    chk(done_cnt == 1, "R8_R9", "done pulses per window", done_cnt, 1);
    chk(ped_rd_o == 1'b0, "R2", "request released", ped_rd_o, 0);
    chk(card_oe_o == 2'b00, "R9", "idle after window", card_oe_o, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) tick();
    chk(ped_rd_o == 0 && fifo_wr_o == 0 && read_done_o == 0, "R1", "reset strobes",
        {ped_rd_o, fifo_wr_o, read_done_o}, 0);
    chk(card_oe_o == 0 && fe_addr_o == 0 && ped_addr_o == 0, "R1", "reset address",
        {card_oe_o, fe_addr_o}, 0);
    chk(fifo_data_o == '0, "R1", "reset data", int'(fifo_data_o[31:0]), 0);
    rst_n = 1'b1;
    tick();
    chk(ped_rd_o == 0 && card_oe_o == 0, "R1", "idle after release",
        {ped_rd_o, card_oe_o}, 0);
    run_window(0, 0,   1'b0, 1'b0);  // R5: thr 0, clamps both ends
    run_window(1, 1,   1'b0, 1'b0);  // R6: smallest nonzero threshold
    run_window(2, 40,  1'b1, 1'b0);  // R10: stall mid scan
    run_window(3, 128, 1'b0, 1'b1);  // R9: start pulses while busy
    run_window(4, 255, 1'b0, 1'b0);  // R6: only saturated values survive
    run_window(5, 200, 1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule